// File: doc/BRIEF.md
# Five-bit parallel port shared with a serial line

This block is a small bidirectional I/O port of five pins. Software programs a direction register and an output latch. Reads of the data register return a mix of latched and pin values. Two of the pins double as a serial line. Pin 3 always feeds the serial receiver. Pin 4 is taken over by the transmitter's line value, and driven, for as long as the transmitter is enabled. The serial engine lives elsewhere and is seen here only as an enable, a line bit and a shift strobe.

The port stays silent after reset. No pin is driven, and every pin output reads 0, until software writes the data register or the enabled transmitter shifts a bit. From then on the direction bits choose the driven pins.

When the direction bits are neither all inputs nor all outputs, every position that is not an output presents 1 on the output vector. When all five are inputs, or all five are outputs, the output vector is the latch itself. An all-input port drives nothing.

Top module: `serport_pins`

## Requirements
- R1: After reset the direction register and latch are 0, no pin is enabled (`pin_oe` = 0), `pin_out` = 0, and reading the direction register returns 8'h00.
- R2: Until the data register is written after reset, `pin_oe` and `pin_out` stay 0, even if the direction register has been written with outputs.
- R3: Once the port has been written, if the low five direction bits are all 0 or all 1, `pin_out` equals latch bits 4:0.
- R4: Once the port has been written, if the low five direction bits are partly set, `pin_out` = (latch & dir) | ~dir over bits 4:0.
- R5: Once the port has been written, `pin_oe` equals direction bits 4:0. Bit 4 is forced to 1 while `tx_enable` is high.
- R6: Once the port has been written and while `tx_enable` is high, `pin_out[4]` equals `tx_bit`.
- R7: A `tx_shift` pulse counts as a port write while `tx_enable` is high, and has no effect while it is low.
- R8: With `reg_sel` = 1 (data register), `rd_data` = ({3'b000, pin_in} & ~dir) | (latch & dir) over all 8 bits.
- R9: With `reg_sel` = 0 (direction register), `rd_data` returns all 8 bits last written to the direction register. The upper three bits have no effect on the pins.
- R10: `rx_line` always equals `pin_in[3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 direction, 1 data |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| tx_enable | input | 1 | Serial transmitter enabled |
| tx_bit | input | 1 | Transmitter line value |
| tx_shift | input | 1 | Transmitter bit-time strobe |
| pin_in | input | 5 | Pin input levels |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Per-pin output enables |
| rx_line | output | 1 | Serial receive line taken from pin 3 |

## Verification
The hardest state to reach is a port that has direction bits set but has never been written. It shows only in the window after reset, before any data write or enabled shift. The stimulus therefore programs the direction register with outputs first, then pulses `tx_shift` with the transmitter disabled, and checks that the pins stay quiet. Only then is the written state entered, once through an enabled shift and again, after a second reset, through a data write.

// File: rtl/serport_pins.sv
module serport_pins #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  output logic [7:0]   rd_data,
  input  logic         tx_enable,
  input  logic         tx_bit,
  input  logic         tx_shift,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         rx_line
);
  localparam int RX_PIN = 3;
  localparam int TX_PIN = 4;
  localparam logic [W-1:0] ALL_OUT = '1;

  logic [7:0]   dir_q;
  logic [7:0]   lat_q;
  logic         written_q;
  logic [W-1:0] dir5;
  logic [W-1:0] base;
  logic [7:0]   pins8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= '0;
      lat_q     <= '0;
      written_q <= 1'b0;
    end else begin
      if (wr_en && !reg_sel) dir_q <= wr_data;
      if (wr_en && reg_sel)  lat_q <= wr_data;
      if ((wr_en && reg_sel) || (tx_shift && tx_enable)) written_q <= 1'b1;
    end
  end

  assign dir5 = dir_q[W-1:0];

  always_comb begin
    if (dir5 != '0 && dir5 != ALL_OUT)
      base = (lat_q[W-1:0] & dir5) | ~dir5;
    else
      base = lat_q[W-1:0];
    if (tx_enable) base[TX_PIN] = tx_bit;
  end

  always_comb begin
    pin_oe = dir5;
    if (tx_enable) pin_oe[TX_PIN] = 1'b1;
    if (!written_q) pin_oe = '0;
  end

  assign pin_out = written_q ? base : '0;
  assign pins8   = {{(8-W){1'b0}}, pin_in};
  assign rd_data = reg_sel ? ((pins8 & ~dir_q) | (lat_q & dir_q)) : dir_q;
  assign rx_line = pin_in[RX_PIN];
endmodule

module serport_pins_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_sel,
  input logic         wr_en,
  input logic         tx_enable,
  input logic         tx_bit,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         rx_line,
  input logic         written_q,
  input logic [7:0]   dir_q
);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !written_q |-> (pin_oe == '0 && pin_out == '0));
  p_datawr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> written_q);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> written_q);
  p_txoe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (written_q && tx_enable) |-> pin_oe[4]);
  p_allin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q[W-1:0] == '0 && !tx_enable) |-> pin_oe == '0);
  p_txbit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (written_q && tx_enable) |-> pin_out[4] == tx_bit);
  p_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_line == pin_in[3]);
endmodule

bind serport_pins serport_pins_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
  .tx_enable(tx_enable), .tx_bit(tx_bit), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .rx_line(rx_line),
  .written_q(written_q), .dir_q(dir_q));

// File: tb/serport_pins_test.sv
module serport_pins_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_enable = 1'b0;
  logic       tx_bit = 1'b0;
  logic       tx_shift = 1'b0;
  logic [4:0] pin_in = 5'h16;
  logic [4:0] pin_out;
  logic [4:0] pin_oe;
  logic       rx_line;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  serport_pins uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tx_enable(tx_enable),
    .tx_bit(tx_bit), .tx_shift(tx_shift), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rx_line(rx_line));

  // {dir, latch, tx_enable, tx_bit, exp_out, exp_oe, exp_rd}, pin_in = 5'h16
  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] lat;
    logic       txe;
    logic       txb;
    logic [4:0] eout;
    logic [4:0] eoe;
    logic [7:0] erd;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h1F, 8'h15, 1'b0, 1'b0, 5'h15, 5'h1F, 8'h15},
    '{8'h00, 8'h0A, 1'b0, 1'b0, 5'h0A, 5'h00, 8'h16},
    '{8'h03, 8'h00, 1'b0, 1'b0, 5'h1C, 5'h03, 8'h14},
    '{8'h0C, 8'h1F, 1'b0, 1'b0, 5'h1F, 5'h0C, 8'h1E},
    '{8'h05, 8'h0A, 1'b0, 1'b0, 5'h1A, 5'h05, 8'h12},
    '{8'h1F, 8'h00, 1'b1, 1'b1, 5'h10, 5'h1F, 8'h00},
    '{8'h00, 8'h1F, 1'b1, 1'b0, 5'h0F, 5'h10, 8'h16},
    '{8'h03, 8'h03, 1'b1, 1'b0, 5'h0F, 5'h13, 8'h17},
    '{8'hE0, 8'h15, 1'b0, 1'b0, 5'h15, 5'h00, 8'h16}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_enable = 1'b0; tx_shift = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    reg_sel = 1'b0;
    #1;
    check("R1 oe", {3'b0, pin_oe}, 8'h00);
    check("R1 out", {3'b0, pin_out}, 8'h00);
    check("R1 dir read", rd_data, 8'h00);

    wr(1'b0, 8'h1F);
    check("R2 oe before write", {3'b0, pin_oe}, 8'h00);
    check("R2 out before write", {3'b0, pin_out}, 8'h00);

    tx_shift = 1'b1; @(negedge clk); tx_shift = 1'b0;
    check("R7 shift while disabled", {3'b0, pin_oe}, 8'h00);

    tx_enable = 1'b1; tx_bit = 1'b1;
    tx_shift = 1'b1; @(negedge clk); tx_shift = 1'b0;
    check("R7 shift while enabled oe", {3'b0, pin_oe}, 8'h1F);
    check("R6 tx bit high", {3'b0, pin_out}, 8'h10);
    tx_bit = 1'b0; #1;
    check("R6 tx bit low", {3'b0, pin_out}, 8'h00);

    do_reset();
    wr(1'b0, 8'h03);
    check("R2 dir only", {3'b0, pin_oe}, 8'h00);
    wr(1'b1, 8'h01);
    check("R2 data write enables", {3'b0, pin_oe}, 8'h03);
    check("R4 after data write", {3'b0, pin_out}, 8'h1D);

    for (int i = 0; i < 9; i++) begin
      wr(1'b0, VECS[i].dir);
      wr(1'b1, VECS[i].lat);
      tx_enable = VECS[i].txe; tx_bit = VECS[i].txb;
      reg_sel = 1'b1;
      #1;
      check($sformatf("R3/R4/R6 out vec %0d", i), {3'b0, pin_out}, {3'b0, VECS[i].eout});
      check($sformatf("R5 oe vec %0d", i), {3'b0, pin_oe}, {3'b0, VECS[i].eoe});
      check($sformatf("R8 data read vec %0d", i), rd_data, VECS[i].erd);
      reg_sel = 1'b0; #1;
      check($sformatf("R9 dir read vec %0d", i), rd_data, VECS[i].dir);
      @(negedge clk);
    end
    tx_enable = 1'b0;

    pin_in = 5'h08; #1;
    check("R10 rx high", {7'b0, rx_line}, 8'h01);
    pin_in = 5'h17; #1;
    check("R10 rx low", {7'b0, rx_line}, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule